// File: doc/BRIEF.md
# Ramped Soft Mute Controller

This block sits in a stereo audio sample path and applies a per-frame gain to each left/right pair of 24-bit signed samples. A frame strobe marks each sample period (one strobe per left/right clock rising edge). With the rate-converted mode selected, a mute request moves the gain one step per frame along a linear ramp between unity and silence. With the passthrough mode selected, the samples are cut to zero, or let through unchanged, starting at the very next frame.

A lock-detect input from the clock recovery loop is tracked by a small qualifier. Loss of lock behaves exactly like a mute request. The unlock indicator stays raised while lock is absent and for a fixed number of frames after lock returns, and the implicit mute lasts for that whole time.

The gain state machine has four states. G_FULL is unity gain. G_DOWN ramps down. G_SILENT is zero gain. G_UP ramps up. Its transitions are: full-to-down when mute arrives; down-to-silent when the gain reaches zero; down-to-up when mute is released mid-ramp; silent-to-up when mute is released; up-to-full when the gain reaches unity; up-to-down when mute returns mid-ramp. In passthrough mode every frame forces the machine to G_FULL or G_SILENT. The lock qualifier has three states. L_UNLOCKED waits for lock. L_QUALIFY counts frames while lock holds. L_LOCKED is normal operation. The transitions are: unlocked-to-qualify when lock is seen; qualify-to-locked on the last counted frame; qualify-to-unlocked and locked-to-unlocked when lock drops.

Top module: `soft_mute_ctrl`

## Requirements
- R1: After reset, out_left and out_right are 0, out_valid is 0, unlock_ind is 1, and the gain is 0 (silent).
- R2: For each frame strobe, the outputs in the next cycle are the input samples times the current gain G (0..1024) divided by 1024, truncated toward zero. The same G is applied to both channels.
- R3: In converted mode (mode_pass=0), while the effective mute (mute_req or unlock_ind) is 1, G falls by one at each frame after it is used, down to 0. Starting from unity, the 1025th muted frame is the first one output with G=0.
- R4: In converted mode without effective mute, G rises by one per frame up to 1024. Starting from 0, the 1025th frame is output at full amplitude.
- R5: A change of mute direction in the middle of a ramp reverses the ramp from the current G, with no restart.
- R6: In passthrough mode (mode_pass=1), the outputs are 0 from the first frame strobe at which the effective mute is 1.
- R7: In passthrough mode, the outputs equal the inputs exactly from the first frame strobe at which the effective mute is 0.
- R8: When pll_locked is 0, unlock_ind is 1 from the next cycle, and frames are processed as muted.
- R9: After pll_locked returns to 1, unlock_ind stays 1 for exactly 1024 further frame strobes and is 0 after the 1024th.
- R10: out_valid is a one-cycle pulse in the cycle after each frame strobe. Between strobes, out_left and out_right hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe per sample frame |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| mute_req | input | 1 | Mute request |
| mode_pass | input | 1 | 1 = passthrough (hard cut), 0 = converted (ramp) |
| pll_locked | input | 1 | Clock recovery lock detect |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| out_valid | output | 1 | Output sample pair is new |
| unlock_ind | output | 1 | Unlock indicator including the qualification period |

## Verification
Samples cycle through positive full scale, negative full scale, minus one, and spread pseudo-random values. Comparing these at every gain step separates truncation toward zero from floor rounding, and a per-channel gain from a shared one. The full ramps from silence to unity and back, and a short ramp that reverses mid-way, pin down the step count and tell reversal apart from restarting. Passthrough frames with mute toggling, plus lock lost and regained, show whether the cut and the 1024-frame qualification fall on the exact frame.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        G_FULL,
        G_DOWN,
        G_SILENT,
        G_UP
    } gain_st_t;

    typedef enum logic [1:0] {
        L_UNLOCKED,
        L_QUALIFY,
        L_LOCKED
    } lock_st_t;
endpackage

// File: rtl/smc_lock_qual.sv
module smc_lock_qual #(
    parameter int QUAL_FRAMES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic pll_locked,
    output logic unlock_ind
);
    import smc_pkg::*;

    localparam int CW = (QUAL_FRAMES > 2) ? $clog2(QUAL_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_FRAMES - 1);

    lock_st_t       st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            L_UNLOCKED: begin
                if (pll_locked) begin
                    st_d  = L_QUALIFY;
                    cnt_d = '0;
                end
            end
            L_QUALIFY: begin
                if (!pll_locked) begin
                    st_d = L_UNLOCKED;
                end else if (frame_stb) begin
                    if (cnt_q == LAST) begin
                        st_d = L_LOCKED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            L_LOCKED: begin
                if (!pll_locked) begin
                    st_d = L_UNLOCKED;
                end
            end
            default: st_d = L_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= L_UNLOCKED;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unlock_ind = (st_q != L_LOCKED);
    end
endmodule

// File: rtl/smc_gain_fsm.sv
module smc_gain_fsm #(
    parameter int GAIN_SHIFT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic                mode_pass,
    input  logic                mute_eff,
    output logic [GAIN_SHIFT:0] gain
);
    import smc_pkg::*;

    localparam int GW = GAIN_SHIFT + 1;
    localparam logic [GW-1:0] UNITY = GW'(1 << GAIN_SHIFT);
    localparam logic [GW-1:0] NEAR_FULL = GW'((1 << GAIN_SHIFT) - 1);
    localparam logic [GW-1:0] ONE = GW'(1);

    gain_st_t       st_q, st_d;
    logic [GW-1:0]  g_q, g_d;

    always_comb begin
        st_d = st_q;
        g_d  = g_q;
        if (frame_stb) begin
            if (mode_pass) begin
                st_d = mute_eff ? G_SILENT : G_FULL;
                g_d  = mute_eff ? '0 : UNITY;
            end else begin
                unique case (st_q)
                    G_FULL: begin
                        if (mute_eff) begin
                            st_d = G_DOWN;
                            g_d  = NEAR_FULL;
                        end
                    end
                    G_DOWN, G_UP: begin
                        if (mute_eff) begin
                            g_d  = g_q - ONE;
                            st_d = (g_q == ONE) ? G_SILENT : G_DOWN;
                        end else begin
                            g_d  = g_q + ONE;
                            st_d = (g_q == NEAR_FULL) ? G_FULL : G_UP;
                        end
                    end
                    G_SILENT: begin
                        if (!mute_eff) begin
                            st_d = G_UP;
                            g_d  = ONE;
                        end
                    end
                    default: begin
                        st_d = G_SILENT;
                        g_d  = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= G_SILENT;
            g_q  <= '0;
        end else begin
            st_q <= st_d;
            g_q  <= g_d;
        end
    end

    always_comb begin
        gain = g_q;
    end
endmodule

// File: rtl/smc_scale.sv
module smc_scale #(
    parameter int SAMPLE_W   = 24,
    parameter int GAIN_SHIFT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_stb,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic        [GAIN_SHIFT:0] gain,
    output logic signed [SAMPLE_W-1:0] sample_out
);
    localparam int PW = SAMPLE_W + GAIN_SHIFT + 2;
    localparam logic signed [PW-1:0] BIAS = PW'((1 << GAIN_SHIFT) - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;
    logic signed [SAMPLE_W-1:0] scaled;

    always_comb begin
        prod   = PW'(sample_in) * PW'($signed({1'b0, gain}));
        biased = prod + (prod[PW-1] ? BIAS : '0);
        scaled = SAMPLE_W'(biased >>> GAIN_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out <= '0;
        end else if (frame_stb) begin
            sample_out <= scaled;
        end
    end
endmodule

// File: rtl/soft_mute_ctrl.sv
module soft_mute_ctrl #(
    parameter int SAMPLE_W    = 24,
    parameter int GAIN_SHIFT  = 10,
    parameter int QUAL_FRAMES = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_stb,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic                       mute_req,
    input  logic                       mode_pass,
    input  logic                       pll_locked,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic                       out_valid,
    output logic                       unlock_ind
);
    localparam int GW = GAIN_SHIFT + 1;
    localparam int NCH = 2;
    localparam logic [GW-1:0] UNITY = GW'(1 << GAIN_SHIFT);

    logic          mute_eff;
    logic [GW-1:0] gain_q;
    logic [GW-1:0] gain_use;
    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];

    smc_lock_qual #(.QUAL_FRAMES(QUAL_FRAMES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .pll_locked (pll_locked),
        .unlock_ind (unlock_ind)
    );

    always_comb begin
        mute_eff = mute_req | unlock_ind;
        gain_use = mode_pass ? (mute_eff ? '0 : UNITY) : gain_q;
        ch_in[0] = in_left;
        ch_in[1] = in_right;
    end

    smc_gain_fsm #(.GAIN_SHIFT(GAIN_SHIFT)) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mode_pass (mode_pass),
        .mute_eff  (mute_eff),
        .gain      (gain_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        smc_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_SHIFT(GAIN_SHIFT)) u_scale (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_stb  (frame_stb),
            .sample_in  (ch_in[c]),
            .gain       (gain_use),
            .sample_out (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= frame_stb;
        end
    end

    always_comb begin
        out_left  = ch_out[0];
        out_right = ch_out[1];
    end
endmodule

// File: rtl/soft_mute_ctrl_chk.sv
module soft_mute_ctrl_chk #(
    parameter int SAMPLE_W   = 24,
    parameter int GAIN_SHIFT = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_stb,
    input logic                mute_req,
    input logic                mode_pass,
    input logic                pll_locked,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right,
    input logic                out_valid,
    input logic                unlock_ind,
    input logic [GAIN_SHIFT:0] gain_q
);
    localparam logic [GAIN_SHIFT:0] UNITY = (GAIN_SHIFT+1)'(1 << GAIN_SHIFT);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> out_valid);

    // R10
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> !out_valid);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(out_left) && $stable(out_right)));

    // R3
    ramp_down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mode_pass && (mute_req || unlock_ind) && gain_q != '0)
        |=> gain_q == $past(gain_q) - 1'b1);

    // R6
    pass_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && mode_pass && mute_req) |=> (out_left == '0 && out_right == '0));

    // R8
    unlock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> unlock_ind);

    // R2
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= UNITY);
endmodule

bind soft_mute_ctrl soft_mute_ctrl_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_SHIFT(GAIN_SHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .mute_req   (mute_req),
    .mode_pass  (mode_pass),
    .pll_locked (pll_locked),
    .out_left   (out_left),
    .out_right  (out_right),
    .out_valid  (out_valid),
    .unlock_ind (unlock_ind),
    .gain_q     (gain_q)
);

// File: tb/soft_mute_ctrl_tb_top.sv
module soft_mute_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 24;
    localparam int UNITY = 1024;
    localparam int QUAL = 1024;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic signed [SW-1:0] in_left = '0;
    logic signed [SW-1:0] in_right = '0;
    logic mute_req = 1'b0;
    logic mode_pass = 1'b0;
    logic pll_locked = 1'b0;
    logic signed [SW-1:0] out_left;
    logic signed [SW-1:0] out_right;
    logic out_valid;
    logic unlock_ind;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_mute_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .in_left    (in_left),
        .in_right   (in_right),
        .mute_req   (mute_req),
        .mode_pass  (mode_pass),
        .pll_locked (pll_locked),
        .out_left   (out_left),
        .out_right  (out_right),
        .out_valid  (out_valid),
        .unlock_ind (unlock_ind)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int exp_l_q [$];
    int exp_r_q [$];
    string tag_q [$];

    int mg = 0;
    int lk = 0;
    int qcnt = 0;
    int fidx = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int smp(input int i, input int ch);
        int v;
        case ((i + ch) % 5)
            0: v = 8388607;
            1: v = -8388608;
            2: v = -1;
            default: v = ((i * 40503 + ch * 977) % 8388608) - 4194304;
        endcase
        return v;
    endfunction

    function automatic int scale(input int s, input int g);
        longint p;
        p = longint'(s) * longint'(g);
        return int'(p / 1024);
    endfunction

    task automatic set_lock(input bit v);
        @(negedge clk);
        pll_locked = v;
        if (!v) lk = 0;
        else if (lk == 0) begin lk = 1; qcnt = 0; end
        @(negedge clk);
    endtask

    task automatic run_frames(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            int sl, sr, g;
            bit meff;
            sl = smp(fidx, 0);
            sr = smp(fidx, 1);
            meff = mute_req || (lk != 2);
            g = mode_pass ? (meff ? 0 : UNITY) : mg;
            exp_l_q.push_back(scale(sl, g));
            exp_r_q.push_back(scale(sr, g));
            tag_q.push_back(tag);
            @(negedge clk);
            in_left = SW'(sl);
            in_right = SW'(sr);
            frame_stb = 1'b1;
            if (mode_pass) mg = meff ? 0 : UNITY;
            else if (meff && mg > 0) mg--;
            else if (!meff && mg < UNITY) mg++;
            if (lk == 1) begin
                if (qcnt == QUAL - 1) lk = 2;
                else qcnt++;
            end
            @(negedge clk);
            frame_stb = 1'b0;
            check((tag == "R9") ? "R9" : "R8", int'(unlock_ind), (lk != 2) ? 1 : 0);
            @(negedge clk);
            @(negedge clk);
            fidx++;
        end
    endtask

    int last_l = 0;
    int last_r = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_l_q.size() == 0) begin
                    check("R10", 1, 0);
                end else begin
                    string t;
                    int el, er;
                    el = exp_l_q.pop_front();
                    er = exp_r_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, int'(out_left), el);
                    check(t, int'(out_right), er);
                end
                last_l = int'(out_left);
                last_r = int'(out_right);
            end else begin
                check("R10", int'(out_left), last_l);
                check("R10", int'(out_right), last_r);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_left), 0);
        check("R1", int'(out_right), 0);
        check("R1", int'(out_valid), 0);
        check("R1", int'(unlock_ind), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(unlock_ind), 1);

        // R8: no lock -> muted, silent
        run_frames(4, "R8");
        // R9: qualification period
        set_lock(1'b1);
        run_frames(QUAL, "R9");
        check("R9", int'(unlock_ind), 0);
        // R4: ramp up from silence
        run_frames(UNITY, "R4");
        // R2: full scale
        run_frames(20, "R2");
        // R3 partial ramp down, R5 reversal
        mute_req = 1'b1;
        run_frames(300, "R3");
        mute_req = 1'b0;
        run_frames(100, "R5");
        mute_req = 1'b1;
        run_frames(50, "R5");
        // R3: full ramp to zero
        run_frames(UNITY, "R3");
        // R6/R7 passthrough
        mode_pass = 1'b1;
        run_frames(3, "R6");
        mute_req = 1'b0;
        run_frames(5, "R7");
        mute_req = 1'b1;
        run_frames(2, "R6");
        mute_req = 1'b0;
        run_frames(3, "R7");
        // R2: converted mode ramp start after passthrough
        mode_pass = 1'b0;
        run_frames(10, "R2");
        // R8: lock lost in passthrough
        mode_pass = 1'b1;
        run_frames(2, "R7");
        set_lock(1'b0);
        check("R8", int'(unlock_ind), 1);
        run_frames(3, "R8");
        set_lock(1'b1);
        run_frames(5, "R9");
        repeat (4) @(negedge clk);
        check("R10", exp_l_q.size(), 0);
        finish_run();
    end
endmodule